// File: doc/BRIEF.md
# Battery Monitor Power-Mode Controller

This block is the mode sequencer of a battery monitor. It keeps the monitor in one of four modes: full-power operation, a low-power sleep, a deep sleep with everything but the regulators off, and a terminal shutdown. Each cycle it decides the next mode from digitized current, pack, stack, per-cell and supply voltages, host command strobes, a reset/shutdown pin, a load-detect comparator and a 1 ms tick. From the mode it drives the FET enables, the protection and measurement enables, a low-power current sample request, a validation measurement request and a shutdown-sequence start.

In sleep, the block asks for a current sample every programmed number of milliseconds. It wakes when the current magnitude is too high, or when the pack terminal rises well above a low stack. After any wake, a seconds-based hold-off keeps it from dropping straight back into sleep. Deep sleep is entered and left only on specific events. Leaving deep sleep always passes through one measurement loop and a programmed settling delay before full operation resumes. Undervoltage on the stack or on any real cell starts the shutdown sequence.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After synchronous reset the mode output is 0 (normal). chg_en, dsg_en, prot_en and meas_en are 1, and lp_req, meas_req and sd_start are 0.
- R2: Mode encoding is 0 normal, 1 sleep, 2 deep sleep (also shown during deep-sleep exit validation), 3 shutdown. In normal mode, sleep_req with no hold-off active gives mode 1 at the next edge. In sleep, dsg_en is 1 and chg_en follows cfg_chg_sleep.
- R3: While in sleep, lp_req pulses for one cycle once every cfg_lp_period ticks (a value of 0 acts as 1).
- R4: In sleep, the mode returns to 0 at the next edge when lp_valid or meas_done is high and the magnitude of the signed cur_sample is strictly greater than cfg_cur_thr. A magnitude equal to the threshold does not wake.
- R5: In sleep, meas_done with pack_v greater than stack_v + cfg_pack_delta (strictly), together with stack_v below cfg_stack_wake, returns the mode to 0. This comparison is made only on meas_done, never on lp_valid.
- R6: Each return to normal from sleep or from validation starts a hold-off. During it, sleep_req is ignored until cfg_hyst_s whole seconds (MS_PER_S ticks each) have elapsed.
- R7: Deep sleep (mode 2) is entered from normal or sleep only on cmd_deep_enter. In deep sleep all four enables are 0. Other commands (cmd_shutdown, cmd_deep_enter, sleep_req) leave the block in deep sleep.
- R8: Deep sleep is left for validation on cmd_deep_exit, on a rst_pin high pulse that ends after fewer than PRESS_MS ticks, or on a 0-to-1 change of ld_above. A longer pulse, or ld_above already high, does not wake.
- R9: Validation holds meas_req high with prot_en and meas_en on and FETs off until meas_done. It then waits cfg_valid_ms ticks and enters normal on the following edge.
- R10: In deep sleep, bat_v + cfg_por_hys < cfg_por_lvl sends the block to shutdown (mode 3) at the next edge.
- R11: The shutdown sequence starts when meas_done arrives in normal, sleep or validation while stack_v < cfg_stack_sd, or while the lowest cell voltage among cells whose icon_mask bit is 0 is below cfg_cell_sd. cmd_shutdown in normal or sleep also starts it.
- R12: Shutdown wins over every wake or exit event in the same cycle. sd_start is a single-cycle pulse on entry. Mode 3 holds until reset, with all enables 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1ms | input | 1 | One-cycle millisecond strobe |
| cur_sample | input | IW | Signed current sample |
| lp_valid | input | 1 | Low-power current sample valid |
| meas_done | input | 1 | Full measurement loop complete, all samples valid |
| pack_v | input | VW | Pack terminal voltage |
| stack_v | input | VW | Top-of-stack voltage |
| bat_v | input | VW | Supply voltage |
| cell_v | input | NCELL*VW | Cell voltages, cell n at bits n*VW upward |
| icon_mask | input | NCELL | 1 marks a cell input used for an interconnect |
| sleep_req | input | 1 | Request to enter sleep |
| cmd_deep_enter | input | 1 | Host command: enter deep sleep |
| cmd_deep_exit | input | 1 | Host command: leave deep sleep |
| cmd_shutdown | input | 1 | Host command: start shutdown |
| rst_pin | input | 1 | Reset/shutdown pin level |
| ld_above | input | 1 | Load-detect comparator output |
| cfg_cur_thr | input | IW | Wake current magnitude threshold |
| cfg_pack_delta | input | VW | Pack-over-stack wake delta |
| cfg_stack_wake | input | VW | Stack ceiling for pack wake |
| cfg_stack_sd | input | VW | Stack shutdown threshold |
| cfg_cell_sd | input | VW | Cell shutdown threshold |
| cfg_por_lvl | input | VW | Supply power-on-reset level |
| cfg_por_hys | input | VW | Hysteresis below that level |
| cfg_lp_period | input | TW | Sleep sample period in ticks |
| cfg_valid_ms | input | TW | Validation delay in ticks |
| cfg_hyst_s | input | SW | Sleep re-entry hold-off in seconds |
| cfg_chg_sleep | input | 1 | Keep charge FET on in sleep |
| mode | output | 2 | Current mode |
| chg_en | output | 1 | Charge FET drive |
| dsg_en | output | 1 | Discharge FET drive |
| prot_en | output | 1 | Protections enabled |
| meas_en | output | 1 | Measurement loop enabled |
| lp_req | output | 1 | Low-power current sample request |
| meas_req | output | 1 | Validation measurement loop request |
| sd_start | output | 1 | Shutdown sequence start pulse |

## Verification
The hardest point to reach from the ports is the sleep re-entry hold-off boundary. A wake has to happen first, and then sleep_req must be held through thousands of ticks, so that the bench can see the request refused just before the programmed seconds expire and accepted just after. The bench gets there with the tick held high every cycle: it wakes the block with an over-threshold sample and samples the mode on both sides of the two-second boundary. The rst_pin pulse length works the same way: a 10-tick and an 1100-tick pulse bracket the 1000-tick limit.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_SLEEP  = 2'd1,
        MODE_DEEP   = 2'd2,
        MODE_SHUT   = 2'd3
    } pmc_mode_e;

    typedef enum logic [2:0] {
        ST_NORMAL,
        ST_SLEEP,
        ST_DEEP,
        ST_VMEAS,
        ST_VWAIT,
        ST_SHUT
    } pmc_state_e;

    // Condition flags produced by the sample evaluator
    typedef struct packed {
        logic cur_over;
        logic pack_high;
        logic sd_trip;
    } pmc_eval_t;

    // Enables driven out of the block
    typedef struct packed {
        logic chg;
        logic dsg;
        logic prot;
        logic meas;
    } pmc_drive_t;

    function automatic pmc_mode_e state_to_mode(pmc_state_e s);
        case (s)
            ST_NORMAL:          return MODE_NORMAL;
            ST_SLEEP:           return MODE_SLEEP;
            ST_DEEP, ST_VMEAS,
            ST_VWAIT:           return MODE_DEEP;
            default:            return MODE_SHUT;
        endcase
    endfunction

    function automatic pmc_drive_t drive_for(pmc_state_e s, logic chg_sleep);
        pmc_drive_t d;
        d = '0;
        case (s)
            ST_NORMAL: begin
                d.chg  = 1'b1;
                d.dsg  = 1'b1;
                d.prot = 1'b1;
                d.meas = 1'b1;
            end
            ST_SLEEP: begin
                d.chg  = chg_sleep;
                d.dsg  = 1'b1;
                d.prot = 1'b1;
                d.meas = 1'b1;
            end
            ST_VMEAS, ST_VWAIT: begin
                d.prot = 1'b1;
                d.meas = 1'b1;
            end
            default: d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pmc_tick_cnt.sv
// Saturating tick counter with synchronous clear (clear wins over count).
module pmc_tick_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         tick,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (tick && (cnt != {W{1'b1}}))
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pmc_cell_min.sv
// Minimum over the cells whose interconnect flag is clear.
module pmc_cell_min #(
    parameter int NCELL = 4,
    parameter int VW    = 16
) (
    input  logic [NCELL*VW-1:0] cell_v,
    input  logic [NCELL-1:0]    icon_mask,
    output logic [VW-1:0]       min_v,
    output logic                have_cell
);
    logic [VW-1:0] run  [0:NCELL];
    logic          seen [0:NCELL];

    assign run[0]  = {VW{1'b1}};
    assign seen[0] = 1'b0;

    for (genvar g = 0; g < NCELL; g++) begin : g_cell
        logic [VW-1:0] v;
        logic          take;
        assign v          = cell_v[g*VW +: VW];
        assign take       = !icon_mask[g] && (v < run[g]);
        assign run[g+1]   = take ? v : run[g];
        assign seen[g+1]  = seen[g] | !icon_mask[g];
    end

    assign min_v     = run[NCELL];
    assign have_cell = seen[NCELL];
endmodule

// File: rtl/pmc_eval.sv
// Threshold comparisons on the current, pack, stack and cell samples.
module pmc_eval
    import pmc_pkg::*;
#(
    parameter int IW = 16,
    parameter int VW = 16
) (
    input  logic signed [IW-1:0] cur_sample,
    input  logic [IW-1:0]        cfg_cur_thr,
    input  logic [VW-1:0]        pack_v,
    input  logic [VW-1:0]        stack_v,
    input  logic [VW-1:0]        cfg_pack_delta,
    input  logic [VW-1:0]        cfg_stack_wake,
    input  logic [VW-1:0]        cfg_stack_sd,
    input  logic [VW-1:0]        min_cell,
    input  logic                 have_cell,
    input  logic [VW-1:0]        cfg_cell_sd,
    output pmc_eval_t            ev
);
    logic signed [IW:0] cur_x;
    logic [IW:0]        mag;
    logic [VW:0]        stack_plus;

    assign cur_x      = {cur_sample[IW-1], cur_sample};
    assign mag        = cur_x[IW] ? IW'(0) - cur_x : cur_x;
    assign stack_plus = {1'b0, stack_v} + {1'b0, cfg_pack_delta};

    always_comb begin
        ev.cur_over  = mag > {1'b0, cfg_cur_thr};
        ev.pack_high = ({1'b0, pack_v} > stack_plus) && (stack_v < cfg_stack_wake);
        ev.sd_trip   = (stack_v < cfg_stack_sd) || (have_cell && (min_cell < cfg_cell_sd));
    end
endmodule

// File: rtl/pmc_hyst.sv
// Seconds hold-off started on each wake; blocks sleep entry while running.
module pmc_hyst #(
    parameter int MS_PER_S = 1000,
    parameter int SW       = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm,
    input  logic          tick,
    input  logic [SW-1:0] hyst_s,
    output logic          hold
);
    localparam int MW = $clog2(MS_PER_S + 1);

    logic [MW-1:0] ms_q;
    logic [SW-1:0] sec_q;
    logic          active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ms_q     <= '0;
            sec_q    <= '0;
            active_q <= 1'b0;
        end else if (arm) begin
            ms_q     <= '0;
            sec_q    <= '0;
            active_q <= 1'b1;
        end else if (tick && active_q) begin
            if (ms_q == MW'(MS_PER_S - 1)) begin
                ms_q <= '0;
                if (sec_q != {SW{1'b1}})
                    sec_q <= sec_q + 1'b1;
            end else begin
                ms_q <= ms_q + 1'b1;
            end
        end
    end

    assign hold = active_q && (sec_q < hyst_s);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int IW       = 16,
    parameter int VW       = 16,
    parameter int NCELL    = 4,
    parameter int TW       = 16,
    parameter int SW       = 8,
    parameter int PRESS_MS = 1000,
    parameter int MS_PER_S = 1000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_1ms,
    input  logic signed [IW-1:0] cur_sample,
    input  logic                 lp_valid,
    input  logic                 meas_done,
    input  logic [VW-1:0]        pack_v,
    input  logic [VW-1:0]        stack_v,
    input  logic [VW-1:0]        bat_v,
    input  logic [NCELL*VW-1:0]  cell_v,
    input  logic [NCELL-1:0]     icon_mask,
    input  logic                 sleep_req,
    input  logic                 cmd_deep_enter,
    input  logic                 cmd_deep_exit,
    input  logic                 cmd_shutdown,
    input  logic                 rst_pin,
    input  logic                 ld_above,
    input  logic [IW-1:0]        cfg_cur_thr,
    input  logic [VW-1:0]        cfg_pack_delta,
    input  logic [VW-1:0]        cfg_stack_wake,
    input  logic [VW-1:0]        cfg_stack_sd,
    input  logic [VW-1:0]        cfg_cell_sd,
    input  logic [VW-1:0]        cfg_por_lvl,
    input  logic [VW-1:0]        cfg_por_hys,
    input  logic [TW-1:0]        cfg_lp_period,
    input  logic [TW-1:0]        cfg_valid_ms,
    input  logic [SW-1:0]        cfg_hyst_s,
    input  logic                 cfg_chg_sleep,
    output logic [1:0]           mode,
    output logic                 chg_en,
    output logic                 dsg_en,
    output logic                 prot_en,
    output logic                 meas_en,
    output logic                 lp_req,
    output logic                 meas_req,
    output logic                 sd_start
);
    localparam int PW = $clog2(PRESS_MS + 1);

    pmc_state_e    state_q, state_d;
    pmc_eval_t     ev;
    pmc_drive_t    drv;
    logic [VW-1:0] min_cell;
    logic          have_cell;
    logic [TW-1:0] lp_cnt, v_cnt;
    logic [PW-1:0] press_cnt;
    logic          ld_prev_q, pin_prev_q, lp_req_q, sd_start_q;
    logic          lp_fire, hyst_hold, hyst_arm;
    logic          bat_low, ld_rise, short_release, sd_event, deep_exit;
    logic [VW:0]   bat_plus;

    // ---------------- sample evaluation ----------------
    pmc_cell_min #(.NCELL(NCELL), .VW(VW)) i_cell_min (
        .cell_v    (cell_v),
        .icon_mask (icon_mask),
        .min_v     (min_cell),
        .have_cell (have_cell)
    );

    pmc_eval #(.IW(IW), .VW(VW)) i_eval (
        .cur_sample     (cur_sample),
        .cfg_cur_thr    (cfg_cur_thr),
        .pack_v         (pack_v),
        .stack_v        (stack_v),
        .cfg_pack_delta (cfg_pack_delta),
        .cfg_stack_wake (cfg_stack_wake),
        .cfg_stack_sd   (cfg_stack_sd),
        .min_cell       (min_cell),
        .have_cell      (have_cell),
        .cfg_cell_sd    (cfg_cell_sd),
        .ev             (ev)
    );

    assign bat_plus = {1'b0, bat_v} + {1'b0, cfg_por_hys};
    assign bat_low  = bat_plus < {1'b0, cfg_por_lvl};

    // ---------------- timers ----------------
    assign lp_fire = (state_q == ST_SLEEP) && tick_1ms &&
                     (({1'b0, lp_cnt} + 1'b1) >= {1'b0, cfg_lp_period});

    pmc_tick_cnt #(.W(TW)) i_lp_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  ((state_q != ST_SLEEP) || lp_fire),
        .tick (tick_1ms),
        .cnt  (lp_cnt)
    );

    pmc_tick_cnt #(.W(TW)) i_valid_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (state_q != ST_VWAIT),
        .tick (tick_1ms),
        .cnt  (v_cnt)
    );

    pmc_tick_cnt #(.W(PW)) i_press_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (!rst_pin),
        .tick (tick_1ms),
        .cnt  (press_cnt)
    );

    assign hyst_arm = (state_d == ST_NORMAL) && (state_q != ST_NORMAL);

    pmc_hyst #(.MS_PER_S(MS_PER_S), .SW(SW)) i_hyst (
        .clk    (clk),
        .rst    (rst),
        .arm    (hyst_arm),
        .tick   (tick_1ms),
        .hyst_s (cfg_hyst_s),
        .hold   (hyst_hold)
    );

    // ---------------- edge detection ----------------
    assign ld_rise       = ld_above && !ld_prev_q;
    assign short_release = pin_prev_q && !rst_pin && (press_cnt < PW'(PRESS_MS));
    assign deep_exit     = cmd_deep_exit || short_release || ld_rise;
    assign sd_event      = meas_done && ev.sd_trip;

    // ---------------- next mode ----------------
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_NORMAL: begin
                if (cmd_shutdown || sd_event)
                    state_d = ST_SHUT;
                else if (cmd_deep_enter)
                    state_d = ST_DEEP;
                else if (sleep_req && !hyst_hold)
                    state_d = ST_SLEEP;
            end
            ST_SLEEP: begin
                if (cmd_shutdown || sd_event)
                    state_d = ST_SHUT;
                else if (cmd_deep_enter)
                    state_d = ST_DEEP;
                else if ((lp_valid && ev.cur_over) ||
                         (meas_done && (ev.cur_over || ev.pack_high)))
                    state_d = ST_NORMAL;
            end
            ST_DEEP: begin
                if (bat_low)
                    state_d = ST_SHUT;
                else if (deep_exit)
                    state_d = ST_VMEAS;
            end
            ST_VMEAS: begin
                if (meas_done)
                    state_d = ev.sd_trip ? ST_SHUT : ST_VWAIT;
            end
            ST_VWAIT: begin
                if (v_cnt >= cfg_valid_ms)
                    state_d = ST_NORMAL;
            end
            default: state_d = ST_SHUT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_NORMAL;
            ld_prev_q  <= 1'b0;
            pin_prev_q <= 1'b0;
            lp_req_q   <= 1'b0;
            sd_start_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            ld_prev_q  <= ld_above;
            pin_prev_q <= rst_pin;
            lp_req_q   <= lp_fire;
            sd_start_q <= (state_d == ST_SHUT) && (state_q != ST_SHUT);
        end
    end

    // ---------------- outputs ----------------
    assign drv      = drive_for(state_q, cfg_chg_sleep);
    assign mode     = state_to_mode(state_q);
    assign chg_en   = drv.chg;
    assign dsg_en   = drv.dsg;
    assign prot_en  = drv.prot;
    assign meas_en  = drv.meas;
    assign lp_req   = lp_req_q;
    assign meas_req = (state_q == ST_VMEAS);
    assign sd_start = sd_start_q;
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode,
    input logic       chg_en,
    input logic       dsg_en,
    input logic       prot_en,
    input logic       meas_en,
    input logic       lp_req,
    input logic       meas_req,
    input logic       sd_start,
    input logic       cmd_deep_enter
);
    // R1: first cycle out of reset is normal with everything on
    a_r1_reset_state: assert property (@(posedge clk)
        $fell(rst) |-> (mode == 2'd0) && chg_en && dsg_en && prot_en && meas_en && !meas_req);

    // R2: sleep is entered only from normal
    a_r2_sleep_from_normal: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd1 && $past(mode) != 2'd1) |-> $past(mode) == 2'd0);

    // R3: a sample request follows a cycle spent in sleep
    a_r3_lpreq_in_sleep: assert property (@(posedge clk) disable iff (rst)
        lp_req |-> $past(mode) == 2'd1);

    // R7: deep sleep is reached from normal/sleep only by the enter command
    a_r7_deep_by_cmd: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd2 && ($past(mode) == 2'd0 || $past(mode) == 2'd1)) |-> $past(cmd_deep_enter));

    // R7: no FET drive in deep sleep or its validation
    a_r7_deep_fets_off: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd2) |-> (!chg_en && !dsg_en));

    // R9: measurement request only during validation with loop enabled
    a_r9_req_in_validation: assert property (@(posedge clk) disable iff (rst)
        meas_req |-> (mode == 2'd2) && meas_en && prot_en);

    // R12: shutdown is sticky and fully off
    a_r12_shut_sticky: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd3) |=> (mode == 2'd3) && !chg_en && !dsg_en && !prot_en && !meas_en);

    // R12: start pulse on entry, one cycle wide
    a_r12_start_on_entry: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd3 && $past(mode) != 2'd3) |-> sd_start);

    a_r12_start_single: assert property (@(posedge clk) disable iff (rst)
        sd_start |=> !sd_start);
endmodule

bind pwr_mode_ctrl pmc_chk i_chk (
    .clk            (clk),
    .rst            (rst),
    .mode           (mode),
    .chg_en         (chg_en),
    .dsg_en         (dsg_en),
    .prot_en        (prot_en),
    .meas_en        (meas_en),
    .lp_req         (lp_req),
    .meas_req       (meas_req),
    .sd_start       (sd_start),
    .cmd_deep_enter (cmd_deep_enter)
);

// File: tb/test_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module test_pwr_mode_ctrl;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               tick_1ms = 1'b1;
    logic signed [15:0] cur_sample;
    logic               lp_valid, meas_done;
    logic [15:0]        pack_v, stack_v, bat_v;
    logic [63:0]        cell_v;
    logic [3:0]         icon_mask;
    logic               sleep_req, cmd_deep_enter, cmd_deep_exit, cmd_shutdown;
    logic               rst_pin, ld_above;
    logic [15:0]        cfg_cur_thr, cfg_pack_delta, cfg_stack_wake, cfg_stack_sd;
    logic [15:0]        cfg_cell_sd, cfg_por_lvl, cfg_por_hys, cfg_lp_period, cfg_valid_ms;
    logic [7:0]         cfg_hyst_s;
    logic               cfg_chg_sleep;
    logic [1:0]         mode;
    logic               chg_en, dsg_en, prot_en, meas_en, lp_req, meas_req, sd_start;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    pwr_mode_ctrl i_pwr_mode_ctrl (
        .clk(clk), .rst(rst), .tick_1ms(tick_1ms), .cur_sample(cur_sample),
        .lp_valid(lp_valid), .meas_done(meas_done), .pack_v(pack_v), .stack_v(stack_v),
        .bat_v(bat_v), .cell_v(cell_v), .icon_mask(icon_mask), .sleep_req(sleep_req),
        .cmd_deep_enter(cmd_deep_enter), .cmd_deep_exit(cmd_deep_exit),
        .cmd_shutdown(cmd_shutdown), .rst_pin(rst_pin), .ld_above(ld_above),
        .cfg_cur_thr(cfg_cur_thr), .cfg_pack_delta(cfg_pack_delta),
        .cfg_stack_wake(cfg_stack_wake), .cfg_stack_sd(cfg_stack_sd),
        .cfg_cell_sd(cfg_cell_sd), .cfg_por_lvl(cfg_por_lvl), .cfg_por_hys(cfg_por_hys),
        .cfg_lp_period(cfg_lp_period), .cfg_valid_ms(cfg_valid_ms),
        .cfg_hyst_s(cfg_hyst_s), .cfg_chg_sleep(cfg_chg_sleep),
        .mode(mode), .chg_en(chg_en), .dsg_en(dsg_en), .prot_en(prot_en),
        .meas_en(meas_en), .lp_req(lp_req), .meas_req(meas_req), .sd_start(sd_start)
    );

    // {is_meas, cur, pack, stack, expect_wake}
    localparam int NV = 12;
    localparam logic [49:0] VECS [NV] = '{
        {1'b0, 16'd50,    16'd20000, 16'd20000, 1'b0},
        {1'b0, 16'd101,   16'd20000, 16'd20000, 1'b1},
        {1'b0, 16'hFF9B,  16'd20000, 16'd20000, 1'b1},
        {1'b0, 16'd100,   16'd20000, 16'd20000, 1'b0},
        {1'b0, 16'hFF9C,  16'd20000, 16'd20000, 1'b0},
        {1'b1, 16'd150,   16'd20000, 16'd20000, 1'b1},
        {1'b1, 16'hFF6A,  16'd20000, 16'd20000, 1'b1},
        {1'b1, 16'd0,     16'd20201, 16'd20000, 1'b1},
        {1'b1, 16'd0,     16'd20200, 16'd20000, 1'b0},
        {1'b1, 16'd0,     16'd31000, 16'd30000, 1'b0},
        {1'b1, 16'd0,     16'd30200, 16'd29999, 1'b1},
        {1'b0, 16'd0,     16'd30200, 16'd29999, 1'b0}
    };

    task automatic chk(input string rq, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cur_sample = '0; lp_valid = 0; meas_done = 0;
        pack_v = 16'd20000; stack_v = 16'd20000; bat_v = 16'd30000;
        cell_v = {4{16'd3000}}; icon_mask = '0;
        sleep_req = 0; cmd_deep_enter = 0; cmd_deep_exit = 0; cmd_shutdown = 0;
        rst_pin = 0; ld_above = 0;
        cfg_cur_thr = 16'd100; cfg_pack_delta = 16'd200; cfg_stack_wake = 16'd30000;
        cfg_stack_sd = 16'd10000; cfg_cell_sd = 16'd2500; cfg_por_lvl = 16'd25000;
        cfg_por_hys = 16'd1000; cfg_lp_period = 16'd3; cfg_valid_ms = 16'd5;
        cfg_hyst_s = 8'd0; cfg_chg_sleep = 1'b0;
        cyc(3);
        rst = 1'b0;
    endtask

    task automatic enter_sleep();
        sleep_req = 1; cyc(1); sleep_req = 0;
    endtask

    task automatic enter_deep();
        cmd_deep_enter = 1; cyc(1); cmd_deep_enter = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        do_reset();
        cyc(1);
        // R1 reset state
        chk("R1 mode", mode, 0);
        chk("R1 enables", {chg_en, dsg_en, prot_en, meas_en}, 4'hF);
        chk("R1 strobes", {lp_req, meas_req, sd_start}, 0);

        // R2 sleep entry and drive
        enter_sleep();
        chk("R2 sleep mode", mode, 1);
        chk("R2 sleep fets", {chg_en, dsg_en}, 2'b01);

        // R3 sample request cadence
        begin
            int pulses = 0;
            for (int k = 0; k < 30; k++) begin
                cyc(1);
                if (lp_req) pulses++;
            end
            chk("R3 lp_req pulses", pulses, 10);
        end

        // R4 / R5 table
        for (int i = 0; i < NV; i++) begin
            if (mode != 2'd1) enter_sleep();
            cur_sample = VECS[i][48:33];
            pack_v     = VECS[i][32:17];
            stack_v    = VECS[i][16:1];
            if (VECS[i][49]) meas_done = 1; else lp_valid = 1;
            cyc(1);
            meas_done = 0; lp_valid = 0;
            chk((i < 7) ? $sformatf("R4 vec%0d", i) : $sformatf("R5 vec%0d", i),
                mode, VECS[i][0] ? 0 : 1);
            cur_sample = '0; pack_v = 16'd20000; stack_v = 16'd20000;
        end

        // R6 hold-off after a wake
        do_reset();
        cfg_hyst_s = 8'd2;
        cyc(1);
        enter_sleep();
        cur_sample = 16'd500; lp_valid = 1; cyc(1); lp_valid = 0; cur_sample = '0;
        chk("R6 woke", mode, 0);
        sleep_req = 1;
        cyc(1985);
        chk("R6 held off", mode, 0);
        cyc(25);
        chk("R6 released", mode, 1);
        sleep_req = 0;

        // R7 deep entry, outputs, ignored commands
        enter_deep();
        chk("R7 deep mode", mode, 2);
        chk("R7 deep enables", {chg_en, dsg_en, prot_en, meas_en}, 0);
        cmd_shutdown = 1; cyc(1); cmd_shutdown = 0;
        sleep_req = 1; cyc(1); sleep_req = 0;
        enter_deep();
        cyc(1);
        chk("R7 other cmds ignored", {mode, meas_req, sd_start}, {2'd2, 2'b00});

        // R8 load-detect already high does not wake; a rise does
        do_reset();
        ld_above = 1; cyc(2);
        enter_deep();
        cyc(3);
        chk("R8 ld level no wake", {mode, meas_req}, {2'd2, 1'b0});
        ld_above = 0; cyc(2);
        ld_above = 1; cyc(1);
        chk("R8 ld rise wakes", meas_req, 1);
        // R9 validation sequence
        chk("R9 validation mode", mode, 2);
        chk("R9 validation enables", {chg_en, dsg_en, prot_en, meas_en}, 4'b0011);
        cyc(3);
        chk("R9 req held", meas_req, 1);
        meas_done = 1; cyc(1); meas_done = 0;
        chk("R9 req dropped", {mode, meas_req}, {2'd2, 1'b0});
        cyc(4);
        chk("R9 still waiting", mode, 2);
        cyc(3);
        chk("R9 normal after delay", mode, 0);
        ld_above = 0;

        // R8 pin pulses and exit command
        do_reset();
        enter_deep();
        rst_pin = 1; cyc(10); rst_pin = 0; cyc(1);
        chk("R8 short press wakes", meas_req, 1);
        do_reset();
        enter_deep();
        rst_pin = 1; cyc(1100); rst_pin = 0; cyc(2);
        chk("R8 long press ignored", {mode, meas_req}, {2'd2, 1'b0});
        cmd_deep_exit = 1; cyc(1); cmd_deep_exit = 0;
        chk("R8 exit command", meas_req, 1);

        // R10 supply collapse in deep sleep
        do_reset();
        enter_deep();
        bat_v = 16'd23000; cyc(1);
        chk("R10 low supply shutdown", mode, 3);
        chk("R12 start pulse", sd_start, 1);
        bat_v = 16'd30000; cyc(1);
        chk("R12 start single", sd_start, 0);
        cmd_deep_exit = 1; sleep_req = 1; cyc(2); cmd_deep_exit = 0; sleep_req = 0;
        chk("R12 sticky", {mode, chg_en, dsg_en, prot_en, meas_en}, {2'd3, 4'b0000});

        // R12 priority over a deep exit in the same cycle
        do_reset();
        enter_deep();
        cmd_deep_exit = 1; bat_v = 16'd23000; cyc(1); cmd_deep_exit = 0;
        chk("R12 priority deep", mode, 3);

        // R11 automatic shutdown triggers
        do_reset();
        stack_v = 16'd9000; meas_done = 1; cyc(1); meas_done = 0;
        chk("R11 stack low", mode, 3);
        do_reset();
        cell_v[47:32] = 16'd2000; meas_done = 1; cyc(1); meas_done = 0;
        chk("R11 cell low", mode, 3);
        do_reset();
        cell_v[47:32] = 16'd2000; icon_mask = 4'b0100; meas_done = 1; cyc(1); meas_done = 0;
        chk("R11 interconnect excluded", mode, 0);
        do_reset();
        enter_sleep();
        cmd_shutdown = 1; cyc(1); cmd_shutdown = 0;
        chk("R11 manual shutdown", mode, 3);

        // R12 wake and shutdown in the same sample from sleep
        do_reset();
        enter_sleep();
        cur_sample = 16'd500; stack_v = 16'd9000; meas_done = 1; cyc(1); meas_done = 0;
        chk("R12 priority sleep", mode, 3);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule